// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block buffers 9-bit words between a producer on one clock and a consumer on an unrelated clock. Storage depth is a power-of-two parameter. Each side has its own enables, and four registered status flags report the fill state. Two flags mark the hard limits: `not_empty` and `not_full`. The other two compare the fill against thresholds that can be changed at run time: `above_low` against the low threshold n, and `below_high` against the high threshold m. A flag is only ever updated by the clock of the side that consumes it.

The level of `put_gate` during reset fixes the operating mode until the next reset.

- **Two-enable mode.** `put_gate` acts as a second, active-high write enable.
- **Load mode.** `put_gate` becomes an active-low load strobe. While it is low, write-side strobes store the two thresholds, and read-side strobes return them on the data output. The order alternates: n first, then m.

Back-pressure follows valid/ready rules:

- `not_full` is the writer's ready. A write strobe given while it is low is dropped.
- `not_empty` is the reader's valid. A read strobe given while it is low leaves the output register untouched.
- The read data is registered. It is presented when `hold_out` is low; `rdata_drv` marks when the output is driven.

Top module: `pflag_async_fifo`

## Requirements
- R1: After reset, `not_empty` and `above_low` are 0, `not_full` and `below_high` are 1, and the output register holds 0. Both thresholds start at 7.
- R2: A word is stored on a rising `wr_clk` edge only when `put_n` is 0, `put_gate` is 1 and `not_full` is 1. In two-enable mode, `put_n` = 0 with `put_gate` = 0 stores nothing.
- R3: `not_full` is 0 exactly when DEPTH words are unread. A write strobe given while full is dropped and leaves the stored sequence unchanged.
- R4: A word is read on a rising `rd_clk` edge only when `take_a_n` and `take_b_n` are both 0 and `not_empty` is 1. A single low enable reads nothing.
- R5: A read strobe while empty leaves `rdata` at the last word read.
- R6: The mode is sampled from `put_gate` while `rst_n` is 0: 1 selects two-enable mode and 0 selects load mode. In load mode, `put_n` = 0 with `put_gate` = 0 stores `wdata[AW:0]` into the thresholds in the alternating order n, m, n, and so on, and writes no FIFO word.
- R7: In load mode, `put_gate` = 0 with both read enables low loads the next threshold into the output register, zero-extended to 9 bits, in the same n, m order. The write sequence and the read sequence each keep their own position.
- R8: `above_low` is 1 exactly when the unread count is greater than n.
- R9: `below_high` is 1 exactly when the unread count is less than DEPTH − m.
- R10: After a write into an empty FIFO, `not_empty` rises on the third or fourth `rd_clk` edge after the write edge. The first word is read on the next `rd_clk` edge after that.
- R11: While `hold_out` is 1, `rdata` is 0 and `rdata_drv` is 0. While it is 0, `rdata` shows the output register and `rdata_drv` is 1.
- R12: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset; the mode is sampled while it is low |
| put_n | input | 1 | Active-low write strobe |
| put_gate | input | 1 | Second write enable (two-enable mode) or active-low threshold access (load mode) |
| wdata | input | 9 | Write data; the low AW+1 bits carry a threshold in load mode |
| take_a_n | input | 1 | Active-low read enable, first |
| take_b_n | input | 1 | Active-low read enable, second |
| hold_out | input | 1 | High forces the data output inactive |
| rdata | output | 9 | Registered read data, gated by `hold_out` |
| rdata_drv | output | 1 | High when `rdata` is driven |
| not_empty | output | 1 | Low when empty; updated on `rd_clk` |
| above_low | output | 1 | High when the unread count is greater than n; updated on `rd_clk` |
| not_full | output | 1 | Low when full; updated on `wr_clk` |
| below_high | output | 1 | High when the unread count is less than DEPTH − m; updated on `wr_clk` |

## Verification
The threshold flags are tested with a fill-then-drain sweep. It steps one word at a time from empty to full and back, checking all four flags against counts computed in the bench. The sweep is run with the default thresholds in two-enable mode and with loaded thresholds in load mode. Stepping through every count separates a comparison that is off by one at n, at n+1, at DEPTH − m or at the hard limits, and shows whether loaded values actually replace the defaults.

Single-strobe patterns are tested on their own:
- a write with only one enable active;
- a read with only one enable low;
- a write while full;
- a read while empty.

Each of these must change no flag and no data. The threshold write and read-back sequences, including a wrap back to n, show that the alternating order is kept on each side.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
  // which threshold register a load-mode access touches next
  typedef enum logic { SEL_LOW = 1'b0, SEL_HIGH = 1'b1 } thr_sel_e;
endpackage

// File: rtl/pflag_gray_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, binary result out.
module pflag_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^(stab_q >> i);
  end
endmodule

// File: rtl/pflag_wr_side.sv
// Write domain: pointer, full / high-threshold flags, threshold registers.
module pflag_wr_side #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int OW    = 5,
  parameter int DEF_N = 7,
  parameter int DEF_M = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put_n,
  input  logic          put_gate,
  input  logic [OW-1:0] thr_in,
  input  logic [AW:0]   rd_bin_s,
  output logic          wr_go,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          not_full,
  output logic          below_high,
  output logic [OW-1:0] thr_n,
  output logic [OW-1:0] thr_m
);
  import pflag_fifo_pkg::*;
  localparam int CW = AW + 2;

  logic                 load_mode;
  logic [AW:0]          wbin, wbin_nx, fill_nx;
  thr_sel_e             wsel;
  logic                 thr_wr;

  // mode captured on each clock edge seen while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) load_mode <= !put_gate;
  end

  assign wr_go   = !put_n && put_gate && not_full;
  assign thr_wr  = load_mode && !put_n && !put_gate;
  assign wbin_nx = wbin + (AW+1)'(wr_go);
  assign fill_nx = wbin_nx - rd_bin_s;
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin       <= '0;
      wgray      <= '0;
      not_full   <= 1'b1;
      below_high <= 1'b1;
    end else begin
      wbin       <= wbin_nx;
      wgray      <= wbin_nx ^ (wbin_nx >> 1);
      not_full   <= fill_nx != (AW+1)'(DEPTH);
      below_high <= (CW'(fill_nx) + CW'(thr_m)) < CW'(DEPTH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_n <= OW'(DEF_N);
      thr_m <= OW'(DEF_M);
      wsel  <= SEL_LOW;
    end else if (thr_wr) begin
      if (wsel == SEL_LOW) thr_n <= thr_in;
      else                 thr_m <= thr_in;
      wsel <= (wsel == SEL_LOW) ? SEL_HIGH : SEL_LOW;
    end
  end
endmodule

// File: rtl/pflag_rd_side.sv
// Read domain: pointer, empty / low-threshold flags, output register.
module pflag_rd_side #(
  parameter int AW = 4,
  parameter int OW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_a_n,
  input  logic                 take_b_n,
  input  logic                 put_gate,
  input  logic [AW:0]          wr_bin_s,
  input  pflag_fifo_pkg::word_t mem_word,
  input  logic [OW-1:0]        thr_n,
  input  logic [OW-1:0]        thr_m,
  output logic [AW-1:0]        raddr,
  output logic [AW:0]          rgray,
  output logic                 not_empty,
  output logic                 above_low,
  output pflag_fifo_pkg::word_t q_reg
);
  import pflag_fifo_pkg::*;
  localparam int CW = AW + 2;

  logic        load_mode;
  logic [AW:0] rbin, rbin_nx, level_nx;
  thr_sel_e    rsel;
  logic        both_low, thr_rd, rd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) load_mode <= !put_gate;
  end

  assign both_low = !take_a_n && !take_b_n;
  assign thr_rd   = load_mode && !put_gate && both_low;
  assign rd_go    = both_low && not_empty && !(load_mode && !put_gate);
  assign rbin_nx  = rbin + (AW+1)'(rd_go);
  assign level_nx = wr_bin_s - rbin_nx;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      not_empty <= 1'b0;
      above_low <= 1'b0;
    end else begin
      rbin      <= rbin_nx;
      rgray     <= rbin_nx ^ (rbin_nx >> 1);
      not_empty <= level_nx != '0;
      above_low <= CW'(level_nx) > CW'(thr_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= '0;
      rsel  <= SEL_LOW;
    end else if (rd_go) begin
      q_reg <= mem_word;
    end else if (thr_rd) begin
      q_reg <= WORD_W'((rsel == SEL_LOW) ? thr_n : thr_m);
      rsel  <= (rsel == SEL_LOW) ? SEL_HIGH : SEL_LOW;
    end
  end
endmodule

// File: rtl/pflag_async_fifo.sv
// Dual-clock FIFO, 9-bit words, run-time fill thresholds. DEPTH <= 256.
module pflag_async_fifo #(
  parameter int DEPTH = 16,
  parameter int DEF_N = 7,
  parameter int DEF_M = 7
) (
  input  logic       wr_clk,
  input  logic       rd_clk,
  input  logic       rst_n,
  input  logic       put_n,
  input  logic       put_gate,
  input  logic [8:0] wdata,
  input  logic       take_a_n,
  input  logic       take_b_n,
  input  logic       hold_out,
  output logic [8:0] rdata,
  output logic       rdata_drv,
  output logic       not_empty,
  output logic       above_low,
  output logic       not_full,
  output logic       below_high
);
  import pflag_fifo_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;

  word_t         mem [DEPTH];
  word_t         mem_word, q_reg;
  logic          wr_go;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wr_bin_s, rd_bin_s;
  logic [OW-1:0] thr_n, thr_m;

  pflag_wr_side #(.DEPTH(DEPTH), .AW(AW), .OW(OW), .DEF_N(DEF_N), .DEF_M(DEF_M)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .put_n(put_n), .put_gate(put_gate),
    .thr_in(wdata[OW-1:0]), .rd_bin_s(rd_bin_s), .wr_go(wr_go), .waddr(waddr),
    .wgray(wgray), .not_full(not_full), .below_high(below_high),
    .thr_n(thr_n), .thr_m(thr_m)
  );

  pflag_rd_side #(.AW(AW), .OW(OW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .take_a_n(take_a_n), .take_b_n(take_b_n),
    .put_gate(put_gate), .wr_bin_s(wr_bin_s), .mem_word(mem_word),
    .thr_n(thr_n), .thr_m(thr_m), .raddr(raddr), .rgray(rgray),
    .not_empty(not_empty), .above_low(above_low), .q_reg(q_reg)
  );

  pflag_gray_sync #(.W(AW+1)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wr_bin_s)
  );

  pflag_gray_sync #(.W(AW+1)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rd_bin_s)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_go) mem[waddr] <= wdata;
  end

  assign mem_word  = mem[raddr];
  assign rdata     = hold_out ? '0 : q_reg;
  assign rdata_drv = !hold_out;
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int PW = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          put_gate,
  input logic          hold_out,
  input logic          not_empty,
  input logic          not_full,
  input logic          above_low,
  input logic          below_high,
  input logic [8:0]    rdata,
  input logic          rdata_drv,
  input logic [PW-1:0] wptr_g,
  input logic [PW-1:0] rptr_g,
  input logic [8:0]    q_reg
);
  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !not_full |=> $stable(wptr_g));
  // R4
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !not_empty |=> $stable(rptr_g));
  // R5
  hold_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!not_empty && put_gate) |=> $stable(q_reg));
  // R8
  low_below_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !not_empty |-> !above_low);
  // R9
  high_when_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !not_full |-> !below_high);
  // R11
  out_gate_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    hold_out |-> (rdata == 9'd0 && !rdata_drv));
  // R1
  reset_exit_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (not_full && below_high));
endmodule

bind pflag_async_fifo pflag_fifo_chk #(.PW(AW+1)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .put_gate(put_gate),
  .hold_out(hold_out), .not_empty(not_empty), .not_full(not_full),
  .above_low(above_low), .below_high(below_high), .rdata(rdata),
  .rdata_drv(rdata_drv), .wptr_g(wgray), .rptr_g(rgray), .q_reg(q_reg)
);

// File: tb/pflag_async_fifo_tb.sv
`timescale 1ns/1ps
module pflag_async_fifo_tb_top;
  localparam int D = 16;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic put_n = 1, put_gate = 1, take_a_n = 1, take_b_n = 1, hold_out = 0;
  logic [8:0] wdata = 0;
  logic [8:0] rdata;
  logic rdata_drv, not_empty, above_low, not_full, below_high;
  int n_chk = 0, n_fail = 0, rd_edges = 0;

  pflag_async_fifo #(.DEPTH(D)) dut_i (.*);

  // 50 MHz write clock, posedges on even ns; read clock posedges on odd ns
  always #10 wr_clk = ~wr_clk;
  initial begin #2; forever #13 rd_clk = ~rd_clk; end
  always @(posedge rd_clk) rd_edges++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(input int base, input int k);
    return 9'((base + k * 37) & 9'h1FF);
  endfunction

  task automatic settle();
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
  endtask

  task automatic do_reset(input bit gate);
    @(negedge wr_clk);
    rst_n = 0; put_gate = gate; put_n = 1; take_a_n = 1; take_b_n = 1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1;
    @(negedge wr_clk);
    put_gate = 1;
    settle();
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge wr_clk); wdata = v; put_n = 0;
    @(negedge wr_clk); put_n = 1;
  endtask

  task automatic pop();
    @(negedge rd_clk); take_a_n = 0; take_b_n = 0;
    @(negedge rd_clk); take_a_n = 1; take_b_n = 1;
  endtask

  task automatic check_flags(input int k, input int n, input int m);
    check(not_empty == (k != 0), "R10 not_empty", not_empty, k != 0);
    check(not_full == (k != D), "R3 not_full", not_full, k != D);
    check(above_low == (k > n), "R8 above_low", above_low, k > n);
    check(below_high == (k < D - m), "R9 below_high", below_high, k < D - m);
  endtask

  task automatic sweep(input int n, input int m, input int base);
    for (int k = 1; k <= D; k++) begin
      push(pat(base, k)); settle(); check_flags(k, n, m);
    end
    push(9'h155); settle();
    check(not_full == 0, "R3 write while full", not_full, 0);
    for (int k = 1; k <= D; k++) begin
      pop();
      check(rdata == pat(base, k), "R12 order", rdata, pat(base, k));
      settle(); check_flags(D - k, n, m);
    end
    pop();
    check(rdata == pat(base, D), "R5 read while empty", rdata, pat(base, D));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int e0, e1;
    // R1 reset state, two-enable mode
    do_reset(1'b1);
    check(not_empty == 0, "R1 not_empty", not_empty, 0);
    check(above_low == 0, "R1 above_low", above_low, 0);
    check(not_full == 1, "R1 not_full", not_full, 1);
    check(below_high == 1, "R1 below_high", below_high, 1);
    check(rdata == 0, "R1 rdata", rdata, 0);

    // R2 second enable low blocks the write
    @(negedge wr_clk); put_gate = 0; put_n = 0; wdata = 9'h0AA;
    @(negedge wr_clk); put_n = 1; put_gate = 1;
    settle();
    check(not_empty == 0, "R2 gated write", not_empty, 0);

    // R10 latency of the empty flag
    @(negedge wr_clk); wdata = 9'h123; put_n = 0;
    @(posedge wr_clk); e0 = rd_edges;
    @(negedge wr_clk); put_n = 1;
    do @(negedge rd_clk); while (!not_empty && rd_edges - e0 < 10);
    e1 = rd_edges;
    check((e1 - e0) >= 3 && (e1 - e0) <= 4, "R10 rise edges", e1 - e0, 3);

    // R4 single enable does not read
    take_a_n = 0;
    @(negedge rd_clk); take_a_n = 1;
    check(rdata == 0, "R4 single enable", rdata, 0);
    settle();
    check(not_empty == 1, "R4 word kept", not_empty, 1);
    pop();
    check(rdata == 9'h123, "R10 first word", rdata, 9'h123);
    settle();
    check(not_empty == 0, "R12 drained", not_empty, 0);

    // R11 output gate
    hold_out = 1; #2;
    check(rdata == 0, "R11 gated data", rdata, 0);
    check(rdata_drv == 0, "R11 drive off", rdata_drv, 0);
    hold_out = 0; #2;
    check(rdata == 9'h123, "R11 data shown", rdata, 9'h123);
    check(rdata_drv == 1, "R11 drive on", rdata_drv, 1);

    // R1 default thresholds, R8 R9 sweep
    sweep(7, 7, 11);

    // R6 load mode: write n=3, m=5
    do_reset(1'b0);
    @(negedge wr_clk); put_gate = 0; put_n = 0; wdata = 9'd3;
    @(negedge wr_clk); wdata = 9'd5;
    @(negedge wr_clk); put_n = 1; put_gate = 1;
    settle();
    check(not_empty == 0, "R6 no FIFO write", not_empty, 0);

    // R7 read-back in order n, m
    @(negedge rd_clk); put_gate = 0; take_a_n = 0; take_b_n = 0;
    @(negedge rd_clk);
    check(rdata == 9'd3, "R7 read n", rdata, 3);
    @(negedge rd_clk); take_a_n = 1; take_b_n = 1;
    check(rdata == 9'd5, "R7 read m", rdata, 5);
    put_gate = 1;
    settle();

    sweep(3, 5, 200);

    // R6 write sequence wraps back to n
    @(negedge wr_clk); put_gate = 0; put_n = 0; wdata = 9'd2;
    @(negedge wr_clk); put_n = 1; put_gate = 1;
    settle();
    @(negedge rd_clk); put_gate = 0; take_a_n = 0; take_b_n = 0;
    @(negedge rd_clk); take_a_n = 1; take_b_n = 1; put_gate = 1;
    check(rdata == 9'd2, "R6 wrap to n", rdata, 2);
    settle();
    // R8 with n=2: three words lift above_low
    push(9'd1); push(9'd2); settle();
    check(above_low == 0, "R8 at n", above_low, 0);
    push(9'd3); settle();
    check(above_low == 1, "R8 at n+1", above_low, 1);

    finish_run();
  end
endmodule